// File: doc/BRIEF.md
# Receive Character Status Tagger

This block sits between a UART character deserializer and the receive-side consumer. Every received character arrives with three error flags: parity, framing and break. The block checks the character against four programmable special characters and an inclusive low/high range. It then builds an 8-bit status byte for the character and stores the data/status pair in a 16-entry FIFO. The consumer drains the FIFO with a valid/ready handshake.

When a character arrives and the FIFO is already full, that character is dropped. The loss is recorded by setting the overrun bit on the newest entry still held in the FIFO.

A receive timer counts bit-clock ticks from the last character. When it expires and the FIFO is empty, the block stores one data-less timeout entry. The timer then stays quiet until the next character arrives. All match values and enables are plain configuration inputs.

Top module: `rx_status_tagger`

## Requirements
- R1: The status byte has this layout. Bit 7 is timeout. Bits 6:4 are the match code. Bit 3 is overrun. Bit 2 is the parity error flag, bit 1 the framing error flag and bit 0 the break flag, each copied from the input. A FIFO entry is 16 bits: the data byte in bits 15:8 and the status byte in bits 7:0.
- R2: The match code is 1 when the character equals special character 1 and 2 when it equals special character 2. Special character k is held in `cfg_spec` bits 8k-1:8k-8. When several comparisons hit at once, the lowest-numbered special character wins, and the range match ranks last.
- R3: Code 3 (equal to special character 3) and code 4 (equal to special character 4) can only occur while `cfg_ext_en` is 1.
- R4: While `cfg_rng_en` is 1, a character with `cfg_rng_lo` <= data <= `cfg_rng_hi` that matches no special character gets code 7. While `cfg_rng_en` is 0, the range never produces a code.
- R5: A character with any error flag set gets code 0 unless `cfg_errmatch_en` is 1. When `cfg_errmatch_en` is 1, it is matched like any other character.
- R6: The FIFO holds 16 entries and returns them in arrival order. `out_valid` is high whenever `level` is nonzero. An entry is removed on a cycle with `out_valid` and `out_ready` both high. A character presented with `in_valid` appears in `level` on the next cycle.
- R7: A character presented while `level` is 16 is discarded, even if a pop happens in the same cycle. `level` does not rise. Bit 3 is set in the status of the most recently stored entry.
- R8: After a character, the timer expires on the N-th `bit_tick`, where N is `cfg_tmo` and 0 counts as 1. At expiry, if the FIFO is empty, the block stores an entry with data 0x00 and status 0x80. The timer fires only once per idle period and is re-armed only by a new character.
- R9: If the FIFO is not empty at expiry, no timeout entry is stored and no overrun is marked.
- R10: After reset the FIFO is empty, `out_valid` is 0, `level` is 0, and the timer is disarmed, so `bit_tick` alone stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A received character is presented this cycle |
| in_data | input | 8 | Received character |
| in_par_err | input | 1 | Parity error flag of the character |
| in_frm_err | input | 1 | Framing error flag of the character |
| in_brk | input | 1 | Break flag of the character |
| bit_tick | input | 1 | One pulse per receive bit time |
| cfg_ext_en | input | 1 | Enables special characters 3 and 4 |
| cfg_rng_en | input | 1 | Enables range matching |
| cfg_errmatch_en | input | 1 | Lets characters with errors be matched |
| cfg_spec | input | 32 | Four special characters, character k in bits 8k-1:8k-8 |
| cfg_rng_lo | input | 8 | Inclusive lower bound of the range |
| cfg_rng_hi | input | 8 | Inclusive upper bound of the range |
| cfg_tmo | input | 8 | Timeout length in bit ticks |
| out_valid | output | 1 | FIFO head is valid |
| out_ready | input | 1 | Consumer takes the head entry |
| out_data | output | 8 | Data byte of the head entry |
| out_stat | output | 8 | Status byte of the head entry |
| level | output | 5 | Number of stored entries |

## Verification
Each result follows one register stage. A character, an overrun mark, a timeout entry or a pop presented in one cycle shows up in `level`, `out_data` and `out_stat` right after the next rising edge. The bench drives inputs at the falling edge, updates its reference queue and timer for that same edge, and compares every output shortly after the rising edge. The timer's expiry is counted in `bit_tick` pulses rather than clock cycles, so the bench counts ticks the same way to predict exactly which edge stores the timeout entry.

// File: rtl/rxst_pkg.sv
package rxst_pkg;
  localparam int DW = 8;
  localparam int SW = 8;
  localparam int NSPEC = 4;

  typedef enum logic [2:0] {
    SC_NONE  = 3'd0,
    SC_CH1   = 3'd1,
    SC_CH2   = 3'd2,
    SC_CH3   = 3'd3,
    SC_CH4   = 3'd4,
    SC_RANGE = 3'd7
  } sc_code_e;

  typedef struct packed {
    logic [DW-1:0] data;
    logic [SW-1:0] stat;
  } rx_entry_t;

  localparam int OVR_BIT = 3;

  function automatic logic [SW-1:0] pack_status(
      input logic tmo, input logic [2:0] code, input logic ovr,
      input logic pe, input logic fe, input logic brk);
    return {tmo, code, ovr, pe, fe, brk};
  endfunction

  function automatic logic in_window(
      input logic [DW-1:0] d, input logic [DW-1:0] lo, input logic [DW-1:0] hi);
    return (d >= lo) && (d <= hi);
  endfunction
endpackage

// File: rtl/rxst_classifier.sv
module rxst_classifier
  import rxst_pkg::*;
#(
  parameter int W = DW,
  parameter int N = NSPEC
) (
  input  logic [W-1:0]   data,
  input  logic           any_err,
  input  logic           ext_en,
  input  logic           rng_en,
  input  logic           errmatch_en,
  input  logic [N*W-1:0] spec,
  input  logic [W-1:0]   rng_lo,
  input  logic [W-1:0]   rng_hi,
  output logic [2:0]     code
);
  logic          eligible;
  logic [N-1:0]  spec_hit;
  logic          rng_hit;

  assign eligible = !any_err || errmatch_en;

  for (genvar k = 0; k < N; k++) begin : g_spec
    if (k < 2) begin : g_base
      assign spec_hit[k] = eligible && (data == spec[k*W +: W]);
    end else begin : g_ext
      assign spec_hit[k] = eligible && ext_en && (data == spec[k*W +: W]);
    end
  end

  assign rng_hit = eligible && rng_en && in_window(data, rng_lo, rng_hi);

  always_comb begin
    code = SC_NONE;
    if (rng_hit) code = SC_RANGE;
    for (int k = N - 1; k >= 0; k--) begin
      if (spec_hit[k]) code = 3'(k + 1);
    end
  end
endmodule

// File: rtl/rxst_timeout.sv
module rxst_timeout #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          char_evt,
  input  logic          tick,
  input  logic [TW-1:0] reload,
  output logic          fire
);
  logic [TW-1:0] cnt_q;
  logic          armed_q;

  assign fire = tick && armed_q && !char_evt && (cnt_q <= TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (char_evt) begin
      cnt_q   <= reload;
      armed_q <= 1'b1;
    end else if (tick && armed_q) begin
      if (cnt_q <= TW'(1)) armed_q <= 1'b0;
      else                 cnt_q   <= cnt_q - TW'(1);
    end
  end

  AST_FIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire) else $error("timer fired twice"); // R8
endmodule

// File: rtl/rxst_fifo.sv
module rxst_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 16,
  parameter int MBIT  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               push_entry,
  input  logic                       mark,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q, last_ptr;
  logic [LW-1:0] cnt_q;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign last_ptr = (wr_q == '0) ? AW'(DEPTH - 1) : wr_q - AW'(1);
  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == LW'(DEPTH));
  assign level    = cnt_q;
  assign head     = mem[rd_q];

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_entry;
    else if (mark) mem[last_ptr][MBIT] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= step_ptr(wr_q);
      if (pop)  rd_q <= step_ptr(rd_q);
      cnt_q <= cnt_q + LW'(push) - LW'(pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LW'(DEPTH)) else $error("fifo level above depth"); // R6
  AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full || pop) else $error("push into full fifo"); // R7
  AST_LEVEL_UP: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop |=> cnt_q == $past(cnt_q) + LW'(1)) else $error("level step"); // R6
endmodule

// File: rtl/rx_status_tagger.sv
module rx_status_tagger
  import rxst_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_par_err,
  input  logic             in_frm_err,
  input  logic             in_brk,
  input  logic             bit_tick,
  input  logic             cfg_ext_en,
  input  logic             cfg_rng_en,
  input  logic             cfg_errmatch_en,
  input  logic [31:0]      cfg_spec,
  input  logic [7:0]       cfg_rng_lo,
  input  logic [7:0]       cfg_rng_hi,
  input  logic [TMO_W-1:0] cfg_tmo,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic [7:0]       out_stat,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int EW = DW + SW;

  logic [2:0] cls_code;
  logic       any_err;
  logic       fifo_empty, fifo_full;
  logic       chr_push, ovr_evt, tmo_fire, tmo_push, do_push, do_pop;
  rx_entry_t  push_entry, head_entry;

  assign any_err = in_par_err || in_frm_err || in_brk;

  rxst_classifier #(.W(DW), .N(NSPEC)) u_cls (
    .data(in_data), .any_err(any_err), .ext_en(cfg_ext_en), .rng_en(cfg_rng_en),
    .errmatch_en(cfg_errmatch_en), .spec(cfg_spec), .rng_lo(cfg_rng_lo),
    .rng_hi(cfg_rng_hi), .code(cls_code)
  );

  rxst_timeout #(.TW(TMO_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .char_evt(in_valid), .tick(bit_tick),
    .reload(cfg_tmo), .fire(tmo_fire)
  );

  assign chr_push = in_valid && !fifo_full;
  assign ovr_evt  = in_valid && fifo_full;
  assign tmo_push = tmo_fire && fifo_empty;
  assign do_push  = chr_push || tmo_push;
  assign do_pop   = out_valid && out_ready;

  always_comb begin
    if (chr_push) begin
      push_entry.data = in_data;
      push_entry.stat = pack_status(1'b0, cls_code, 1'b0, in_par_err, in_frm_err, in_brk);
    end else begin
      push_entry.data = '0;
      push_entry.stat = pack_status(1'b1, SC_NONE, 1'b0, 1'b0, 1'b0, 1'b0);
    end
  end

  rxst_fifo #(.DEPTH(DEPTH), .W(EW), .MBIT(OVR_BIT)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(do_push), .push_entry(push_entry),
    .mark(ovr_evt), .pop(do_pop), .head(head_entry), .empty(fifo_empty),
    .full(fifo_full), .level(level)
  );

  assign out_valid = !fifo_empty;
  assign out_data  = head_entry.data;
  assign out_stat  = head_entry.stat;

  AST_EXT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !cfg_ext_en |-> cls_code != 3'd3 && cls_code != 3'd4)
    else $error("ext code without enable"); // R3
  AST_ERR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && any_err && !cfg_errmatch_en |-> cls_code == 3'd0)
    else $error("error char matched"); // R5
  AST_RNG_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !cfg_rng_en |-> cls_code != 3'd7)
    else $error("range code without enable"); // R4
  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt && !do_pop |=> level == DEPTH[$bits(level)-1:0])
    else $error("overrun changed level"); // R7
  AST_TMO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_push |=> out_valid && out_stat == 8'h80 && out_data == 8'h00)
    else $error("timeout entry malformed"); // R8
  AST_TMO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_fire && !fifo_empty && !in_valid |=> level == $past(level) - $bits(level)'($past(do_pop)))
    else $error("timeout stored into busy fifo"); // R9
endmodule

// File: tb/rx_status_tagger_tb_top.sv
`timescale 1ns/1ps
module rx_status_tagger_tb_top;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_par_err = 0, in_frm_err = 0, in_brk = 0, bit_tick = 0;
  logic [7:0] in_data = 0;
  logic cfg_ext_en = 0, cfg_rng_en = 0, cfg_errmatch_en = 0, out_ready = 0;
  logic [31:0] cfg_spec = 0;
  logic [7:0] cfg_rng_lo = 0, cfg_rng_hi = 0, cfg_tmo = 0;
  logic out_valid;
  logic [7:0] out_data, out_stat;
  logic [4:0] level;

  int total = 0, bad = 0;
  string cur_req = "R10";
  logic [15:0] q[$];
  int t_cnt = 0;
  bit t_arm = 0;

  always #2 clk = ~clk;

  rx_status_tagger dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_par_err(in_par_err), .in_frm_err(in_frm_err), .in_brk(in_brk),
    .bit_tick(bit_tick), .cfg_ext_en(cfg_ext_en), .cfg_rng_en(cfg_rng_en),
    .cfg_errmatch_en(cfg_errmatch_en), .cfg_spec(cfg_spec), .cfg_rng_lo(cfg_rng_lo),
    .cfg_rng_hi(cfg_rng_hi), .cfg_tmo(cfg_tmo), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_stat(out_stat), .level(level)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected match code, restated from R2..R5
  function automatic logic [2:0] exp_code(input logic [7:0] d, input bit err);
    if (err && !cfg_errmatch_en) return 3'd0;
    if (d == cfg_spec[7:0])   return 3'd1;
    if (d == cfg_spec[15:8])  return 3'd2;
    if (cfg_ext_en && d == cfg_spec[23:16]) return 3'd3;
    if (cfg_ext_en && d == cfg_spec[31:24]) return 3'd4;
    if (cfg_rng_en && d >= cfg_rng_lo && d <= cfg_rng_hi) return 3'd7;
    return 3'd0;
  endfunction

  task automatic step(input bit iv, input logic [7:0] d, input bit pe, input bit fe,
                      input bit bk, input bit tk, input bit rd);
    int sz;
    @(negedge clk);
    in_valid = iv; in_data = d; in_par_err = pe; in_frm_err = fe; in_brk = bk;
    bit_tick = tk; out_ready = rd;
    sz = q.size();
    if (iv && sz == 16) q[sz-1][3] = 1'b1;           // R7 mark newest
    if (rd && sz > 0) void'(q.pop_front());
    if (iv) begin
      if (sz < 16) q.push_back({d, 1'b0, exp_code(d, pe | fe | bk), 1'b0, pe, fe, bk});
      t_cnt = cfg_tmo; t_arm = 1;
    end else if (tk && t_arm) begin
      if (t_cnt <= 1) begin
        t_arm = 0;
        if (sz == 0) q.push_back(16'h0080);           // R8
      end else t_cnt--;
    end
    @(posedge clk); #1;
    chk(cur_req, {31'd0, out_valid}, {31'd0, q.size() > 0});
    chk(cur_req, {27'd0, level}, q.size());
    if (q.size() > 0) chk(cur_req, {out_data, out_stat}, {16'd0, q[0]});
    in_valid = 0; bit_tick = 0; out_ready = 0;
  endtask

  task automatic expect_one(input string req, input logic [7:0] d, input bit pe,
                            input bit fe, input bit bk, input logic [15:0] exp);
    cur_req = req;
    step(1, d, pe, fe, bk, 0, 0);
    chk(req, {out_data, out_stat}, exp);
    step(0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R6 actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    cfg_tmo = 8'd2;
    repeat (3) @(posedge clk);
    #1;
    chk("R10", {31'd0, out_valid}, 0);
    chk("R10", {27'd0, level}, 0);
    @(negedge clk); rst_n = 1;
    cur_req = "R10";
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 1, 0);
    chk("R10", {27'd0, level}, 0);

    cfg_spec = 32'h44434141;
    expect_one("R2", 8'h41, 0, 0, 0, 16'h4110);
    expect_one("R1", 8'h55, 1, 1, 1, 16'h5507);
    cfg_spec = 32'h44434241;
    expect_one("R2", 8'h42, 0, 0, 0, 16'h4220);
    expect_one("R3", 8'h43, 0, 0, 0, 16'h4300);
    cfg_ext_en = 1;
    expect_one("R3", 8'h43, 0, 0, 0, 16'h4330);
    expect_one("R3", 8'h44, 0, 0, 0, 16'h4440);
    cfg_rng_lo = 8'h30; cfg_rng_hi = 8'h39; cfg_rng_en = 1;
    expect_one("R4", 8'h30, 0, 0, 0, 16'h3070);
    expect_one("R4", 8'h39, 0, 0, 0, 16'h3970);
    expect_one("R4", 8'h3A, 0, 0, 0, 16'h3A00);
    expect_one("R4", 8'h2F, 0, 0, 0, 16'h2F00);
    cfg_spec[7:0] = 8'h35;
    expect_one("R2", 8'h35, 0, 0, 0, 16'h3510);
    cfg_rng_en = 0;
    expect_one("R4", 8'h36, 0, 0, 0, 16'h3600);
    cfg_spec[7:0] = 8'h41;
    expect_one("R5", 8'h41, 1, 0, 0, 16'h4104);
    cfg_errmatch_en = 1;
    expect_one("R5", 8'h41, 1, 0, 0, 16'h4114);
    expect_one("R5", 8'h41, 0, 1, 0, 16'h4112);
    cfg_errmatch_en = 0;

    cur_req = "R7";
    for (int i = 0; i < 16; i++) step(1, 8'h60 + 8'(i), 0, 0, 0, 0, 0);
    step(1, 8'h7F, 0, 0, 0, 0, 0);
    chk("R7", {27'd0, level}, 16);
    step(1, 8'h7E, 0, 0, 0, 0, 1);
    chk("R7", {27'd0, level}, 15);
    cur_req = "R6";
    for (int i = 1; i < 15; i++) begin
      chk("R6", {24'd0, out_data}, 8'h60 + 8'(i));
      step(0, 0, 0, 0, 0, 0, 1);
    end
    chk("R7", {out_data, out_stat}, 16'h6F08);
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R6", {27'd0, level}, 0);

    cur_req = "R8";
    cfg_tmo = 8'd3;
    step(1, 8'h20, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R8", {27'd0, level}, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R8", {out_data, out_stat}, 16'h0080);
    step(0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 0, 1, 0);
    chk("R8", {27'd0, level}, 0);

    cur_req = "R9";
    step(1, 8'h20, 0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 1, 0);
    chk("R9", {27'd0, level}, 1);
    chk("R9", {out_data, out_stat}, 16'h2000);
    step(0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 1, 0);
    chk("R9", {27'd0, level}, 0);

    cur_req = "R6";
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] d;
      if (n % 500 == 0) begin
        cfg_spec = {8'h40 + 8'($urandom_range(0, 7)), 8'h40 + 8'($urandom_range(0, 7)),
                    8'h40 + 8'($urandom_range(0, 7)), 8'h40 + 8'($urandom_range(0, 7))};
        cfg_rng_lo = 8'h40 + 8'($urandom_range(0, 15));
        cfg_rng_hi = 8'h40 + 8'($urandom_range(0, 15));
        cfg_ext_en = 1'($urandom_range(0, 1));
        cfg_rng_en = 1'($urandom_range(0, 1));
        cfg_errmatch_en = 1'($urandom_range(0, 1));
        cfg_tmo = 8'($urandom_range(0, 6));
      end
      d = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h40 + 8'($urandom_range(0, 15));
      step($urandom_range(0, 9) < 4, d, $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0,
           $urandom_range(0, 9) == 0, $urandom_range(0, 9) < 3,
           (n / 700) % 2 == 0 ? $urandom_range(0, 9) < 4 : $urandom_range(0, 9) < 1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule